// File: doc/BRIEF.md
# Synchronous Excitation and Reference Generator

This block drives the on/off modulation of a light source and supplies the matching sine and cosine references that a downstream lock-in demodulator multiplies against the ADC data. The modulation clock is not timed from the system clock. It is derived from the per-channel ADC sample strobe, so the square wave and the references always share the sampling grid. The modulation frequency is restricted to Fs / (2n + 0.5). With this choice, the odd harmonics of the square wave that alias back into the sampled band never land on the fundamental.

A frequency index n selects the period. A half-sample accumulator runs modulo 4n + 1 and advances by two units on every strobe. The LED clock level and the reference phase both come from that one accumulator, so the references are locked to the LED clock edge by construction. A two-bit colour code selects one of three LED drive lines, or none of them. The enable input blanks the light without stopping the references, so that a dark-signal measurement still has a running demodulator.

Top module: `exc_ref_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `led_clk`, `led_sel`, `ref_sin` and `ref_cos` are all zero after that edge, and the half-sample accumulator returns to 0.
- R2: The frequency index is clamped to the range 4..60. An index below 4 behaves as 4 and an index above 60 behaves as 60.
- R3: Each strobe advances the accumulator `a` by 2 modulo P = 4n+1. With `en` high, `led_clk` is high while a < 2n+1 and low otherwise, which gives a period of 2n+0.5 strobes.
- R4: The reference phase index is bits [19:10] of a * floor(2^20 / P), a 10-bit value covering one turn. It is therefore zero or nearly zero in the strobe where `led_clk` rises.
- R5: For phase index p, `ref_sin` equals round(32767 * sin(2*pi*(p+0.5)/1024)) within 1 LSB, in signed 16-bit form.
- R6: `ref_cos` equals round(32767 * cos(2*pi*(p+0.5)/1024)) within 1 LSB. It leads `ref_sin` by 90 degrees.
- R7: With `en` high, colour code 0, 1 and 2 drive `led_sel` = 3'b001, 3'b010 and 3'b100. Code 3 drives 3'b000. At most one bit is ever high.
- R8: With `en` low, `led_clk` and `led_sel` are zero one cycle later. The accumulator and both references keep advancing on strobes.
- R9: `led_sel` and the enable blanking take effect at the first clock edge after the input changes. A strobe sampled at edge k updates the accumulator at edge k, `led_clk` at edge k+1 and the references at edge k+2.
- R10: Without strobes, the accumulator, `led_clk` (with `en` and colour held) and both references stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Light enable; low blanks the LED clock and selects |
| smp_stb | input | 1 | One-cycle pulse per per-channel ADC sample |
| freq_idx | input | 6 | Frequency index n; period is 2n+0.5 samples |
| color_sel | input | 2 | LED colour code; 3 selects no LED |
| led_clk | output | 1 | Square-wave modulation clock |
| led_sel | output | 3 | One-hot LED drive select |
| ref_sin | output | 16 | Signed in-phase reference |
| ref_cos | output | 16 | Signed quadrature reference |

## Verification
The hardest state to reach from the ports is an accumulator wrap that leaves a residue of 1. In that case the rising LED edge fell half a sample before the strobe, and the phase must restart at one half-step instead of zero. This residue only shows up on every other period, and the exact sequence depends on n. The stimulus therefore runs more than 4n+1 consecutive strobes for each of several indices, including the two clamp limits, and compares every strobe against a model that tracks the accumulator. This covers both wrap residues and every quadrant of the sine table.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    COL_0   = 2'd0,
    COL_1   = 2'd1,
    COL_2   = 2'd2,
    COL_OFF = 2'd3
  } col_e;

  function automatic logic [2:0] col_decode(input col_e c);
    logic [2:0] r;
    r = 3'b000;
    case (c)
      COL_0:   r = 3'b001;
      COL_1:   r = 3'b010;
      COL_2:   r = 3'b100;
      default: r = 3'b000;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/exc_cfg.sv
module exc_cfg #(
  parameter int NW    = 6,
  parameter int N_MIN = 4,
  parameter int N_MAX = 60,
  parameter int PW    = 20,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic [NW-1:0] freq_idx,
  output logic [AW-1:0] per,
  output logic [AW-1:0] hi_lim,
  output logic [PW-1:0] hstep
);
  logic [NW-1:0] n_c;
  logic [AW-1:0] per_c;

  always_comb begin
    if (int'(freq_idx) < N_MIN)      n_c = NW'(N_MIN);
    else if (int'(freq_idx) > N_MAX) n_c = NW'(N_MAX);
    else                             n_c = freq_idx;
    per_c = AW'(4 * int'(n_c) + 1);
  end

  // configuration pipeline: no reset needed, reloads every cycle
  always_ff @(posedge clk) begin
    per    <= per_c;
    hi_lim <= AW'(2 * int'(n_c) + 1);
    hstep  <= PW'((33'd1 << PW) / {{(33-AW){1'b0}}, per_c});
  end
endmodule

// File: rtl/exc_phase_timer.sv
module exc_phase_timer #(
  parameter int PW    = 20,
  parameter int AW    = 8,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_stb,
  input  logic [AW-1:0]    per,
  input  logic [AW-1:0]    hi_lim,
  input  logic [PW-1:0]    hstep,
  output logic             lvl,
  output logic [IDX_W-1:0] ph_idx
);
  logic [AW-1:0]    acc;
  logic [AW:0]      sum;
  logic [AW+PW-1:0] prod;

  assign sum = {1'b0, acc} + (AW+1)'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (smp_stb) begin
      if (sum >= {1'b0, per})
        acc <= (acc >= per) ? '0 : AW'(sum - {1'b0, per});
      else
        acc <= sum[AW-1:0];
    end
  end

  assign lvl    = (acc < hi_lim);
  assign prod   = acc * hstep;
  assign ph_idx = prod[PW-1 -: IDX_W];

  // R10
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> $stable(acc));

  // R4
  edge_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl) |-> (acc <= AW'(1)));
endmodule

// File: rtl/exc_sine_rom.sv
module exc_sine_rom #(
  parameter int IDX_W = 10,
  parameter int DW    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IDX_W-1:0]     ph_idx,
  output logic signed [DW-1:0] ref_sin,
  output logic signed [DW-1:0] ref_cos
);
  localparam int    QW   = IDX_W - 2;
  localparam int    QN   = 1 << QW;
  localparam longint ONE = 64'sd1 << 30;
  localparam longint HPI = 64'sd1686629713;   // pi/2 in Q30
  localparam longint AMP = (64'sd1 << (DW-1)) - 1;

  // quarter-wave magnitude at the midpoint of slot i, odd Taylor series in Q30
  function automatic logic [DW-2:0] qsin(input int i);
    longint x, x2, t, s;
    x  = (HPI * longint'(2*i + 1)) / longint'(2*QN);
    x2 = (x * x) >>> 30;
    t  = ONE - x2 / 72;
    t  = ONE - ((x2 * t) >>> 30) / 42;
    t  = ONE - ((x2 * t) >>> 30) / 20;
    t  = ONE - ((x2 * t) >>> 30) / 6;
    s  = (x * t) >>> 30;
    return (DW-1)'((s * AMP + (ONE >>> 1)) >>> 30);
  endfunction

  logic [DW-2:0] qtab [QN];
  for (genvar g = 0; g < QN; g++) begin : g_tab
    assign qtab[g] = qsin(g);
  end

  logic [1:0]    q_s, q_c;
  logic [QW-1:0] ad_s, ad_c;
  logic [DW-2:0] mag_s, mag_c;
  logic          neg_s, neg_c;

  always_comb begin
    q_s  = ph_idx[IDX_W-1 -: 2];
    q_c  = q_s + 2'd1;
    ad_s = q_s[0] ? ~ph_idx[QW-1:0] : ph_idx[QW-1:0];
    ad_c = q_c[0] ? ~ph_idx[QW-1:0] : ph_idx[QW-1:0];
  end

  // table read stage, no reset so it maps onto a dual-port ROM
  always_ff @(posedge clk) begin
    mag_s <= qtab[ad_s];
    mag_c <= qtab[ad_c];
    neg_s <= q_s[1];
    neg_c <= q_c[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_sin <= '0;
      ref_cos <= '0;
    end else begin
      ref_sin <= neg_s ? -$signed({1'b0, mag_s}) : $signed({1'b0, mag_s});
      ref_cos <= neg_c ? -$signed({1'b0, mag_c}) : $signed({1'b0, mag_c});
    end
  end
endmodule

// File: rtl/exc_ref_gen.sv
module exc_ref_gen #(
  parameter int NW    = 6,
  parameter int N_MIN = 4,
  parameter int N_MAX = 60,
  parameter int PW    = 20,
  parameter int IDX_W = 10,
  parameter int DW    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 smp_stb,
  input  logic [NW-1:0]        freq_idx,
  input  logic [1:0]           color_sel,
  output logic                 led_clk,
  output logic [2:0]           led_sel,
  output logic signed [DW-1:0] ref_sin,
  output logic signed [DW-1:0] ref_cos
);
  import exc_pkg::*;

  localparam int PER_MAX = 4 * N_MAX + 1;
  localparam int AW      = $clog2(PER_MAX + 2);

  logic [AW-1:0]    per, hi_lim;
  logic [PW-1:0]    hstep;
  logic             lvl;
  logic [IDX_W-1:0] ph_idx;

  exc_cfg #(.NW(NW), .N_MIN(N_MIN), .N_MAX(N_MAX), .PW(PW), .AW(AW)) u_cfg (
    .clk(clk), .freq_idx(freq_idx), .per(per), .hi_lim(hi_lim), .hstep(hstep)
  );

  exc_phase_timer #(.PW(PW), .AW(AW), .IDX_W(IDX_W)) u_tmr (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .per(per), .hi_lim(hi_lim),
    .hstep(hstep), .lvl(lvl), .ph_idx(ph_idx)
  );

  exc_sine_rom #(.IDX_W(IDX_W), .DW(DW)) u_rom (
    .clk(clk), .rst(rst), .ph_idx(ph_idx), .ref_sin(ref_sin), .ref_cos(ref_cos)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      led_clk <= 1'b0;
      led_sel <= 3'b000;
    end else begin
      led_clk <= en & lvl;
      led_sel <= en ? col_decode(col_e'(color_sel)) : 3'b000;
    end
  end

  // cycles since the last strobe or reset, saturating at 3
  logic [1:0] quiet;
  always_ff @(posedge clk) begin
    if (rst || smp_stb) quiet <= 2'd0;
    else if (quiet != 2'd3) quiet <= quiet + 2'd1;
  end

  // R7
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(led_sel));

  // R8
  dark_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!led_clk && led_sel == 3'b000));

  // R10
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet == 2'd3) |-> ($stable(ref_sin) && $stable(ref_cos)));
endmodule

// File: tb/tb_exc_ref_gen.sv
module tb_exc_ref_gen;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en = 1'b0;
  logic              smp_stb = 1'b0;
  logic [5:0]        freq_idx = 6'd12;
  logic [1:0]        color_sel = 2'd0;
  logic              led_clk;
  logic [2:0]        led_sel;
  logic signed [15:0] ref_sin, ref_cos;

  exc_ref_gen dut (
    .clk(clk), .rst(rst), .en(en), .smp_stb(smp_stb), .freq_idx(freq_idx),
    .color_sel(color_sel), .led_clk(led_clk), .led_sel(led_sel),
    .ref_sin(ref_sin), .ref_cos(ref_cos)
  );

  always #4 clk = ~clk;   // 125 MHz

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    due;
    logic  lc;
    logic [2:0] sel;
    int    s, c;
    string tag;
  } item_t;
  item_t sbq[$];

  // bench model
  int n_m, per_m, hs_m, a_m;
  logic en_m;
  logic [1:0] col_m;

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic logic [2:0] sel_exp(input logic e, input logic [1:0] c);
    if (!e || c == 2'd3) return 3'b000;
    return 3'b001 << c;
  endfunction

  task automatic chk_bit(input string tag, input int act, input int exp, input int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_n(input int n);
    freq_idx = 6'(n);
    n_m   = (n < 4) ? 4 : (n > 60 ? 60 : n);
    per_m = 4 * n_m + 1;
    hs_m  = (1 << 20) / per_m;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk_bit("R1 led_clk", int'(led_clk), 0, 0);
    chk_bit("R1 led_sel", int'(led_sel), 0, 0);
    chk_bit("R1 ref_sin", int'(ref_sin), 0, 0);
    chk_bit("R1 ref_cos", int'(ref_cos), 0, 0);
    rst = 1'b0;
    a_m = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_in(input logic e, input logic [1:0] c);
    @(negedge clk);
    en = e; color_sel = c; en_m = e; col_m = c;
    @(negedge clk);
  endtask

  // driver: one strobe, expected outputs pushed into the scoreboard
  task automatic strobe(input string tag);
    item_t it;
    int p;
    real ang;
    @(negedge clk);
    smp_stb = 1'b1;
    a_m = a_m + 2;
    if (a_m >= per_m) a_m = a_m - per_m;
    p   = ((a_m * hs_m) >> 10) & 1023;
    ang = 2.0 * 3.14159265358979 * (real'(p) + 0.5) / 1024.0;
    it.due = cyc + 3;
    it.lc  = en_m && (a_m < 2 * n_m + 1);
    it.sel = sel_exp(en_m, col_m);
    it.s   = rnd(32767.0 * $sin(ang));
    it.c   = rnd(32767.0 * $cos(ang));
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    smp_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (sbq.size() != 0 && sbq[0].due == cyc) begin
      item_t it;
      it = sbq.pop_front();
      chk_bit({it.tag, " R3 led_clk"}, int'(led_clk), int'(it.lc), 0);
      chk_bit({it.tag, " R7 led_sel"}, int'(led_sel), int'(it.sel), 0);
      chk_bit({it.tag, " R5 ref_sin"}, int'(ref_sin), it.s, 1);
      chk_bit({it.tag, " R6 ref_cos"}, int'(ref_cos), it.c, 1);
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic lc0;
    logic signed [15:0] s0, c0;
    en_m = 1'b1; col_m = 2'd0;
    en = 1'b1; color_sel = 2'd0;
    set_n(12);
    do_reset();                                  // R1
    for (int i = 0; i < 110; i++) strobe("n12 R4 R9");
    set_in(1'b1, 2'd1); for (int i = 0; i < 6; i++) strobe("col1 R7");
    set_in(1'b1, 2'd2); for (int i = 0; i < 6; i++) strobe("col2 R7");
    set_in(1'b1, 2'd3); for (int i = 0; i < 6; i++) strobe("col3 R7");
    set_in(1'b0, 2'd0); for (int i = 0; i < 30; i++) strobe("disabled R8");
    set_in(1'b1, 2'd1);
    // R10: outputs hold without strobes
    repeat (4) @(negedge clk);
    lc0 = led_clk; s0 = ref_sin; c0 = ref_cos;
    repeat (12) @(negedge clk);
    chk_bit("R10 led_clk hold", int'(led_clk), int'(lc0), 0);
    chk_bit("R10 ref_sin hold", int'(ref_sin), int'(s0), 0);
    chk_bit("R10 ref_cos hold", int'(ref_cos), int'(c0), 0);
    set_n(13);  do_reset(); for (int i = 0; i < 120; i++) strobe("n13 R3");
    set_n(0);   do_reset(); for (int i = 0; i < 40; i++)  strobe("n0 clamp R2");
    set_n(63);  do_reset(); for (int i = 0; i < 500; i++) strobe("n63 clamp R2");
    set_n(4);   do_reset(); for (int i = 0; i < 40; i++)  strobe("n4 R4");
    repeat (6) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule